// File: doc/BRIEF.md
# Single-Channel Memory/I-O Transfer Engine

This block is a self-timed byte mover that becomes bus master on a shared 8-bit data bus with a 20-bit address. Software presents a source address, a destination address, a byte count, an I/O-or-memory flag and an address step code for each side, and a bus-ownership mode. It then pulses `start`. The engine asks the CPU for the bus with `bus_req` and waits for `bus_grant`. It then moves the block one byte at a time. Each byte is a read cycle into an internal holding register, followed by a write cycle from that register.

Bus cycles leave the engine on a valid/ready channel. A cycle is offered by raising `bus_valid` with `bus_write`, `bus_io`, `bus_addr` and `bus_wdata`. It completes on the first clock edge where `bus_ready` is also high. Until then, every field is held unchanged, so a slow memory or peripheral applies back-pressure by keeping `bus_ready` low. For reads, `bus_rdata` is taken on the completing edge.

Three ownership modes are available:
- **Burst** keeps the bus for the whole block.
- **Cycle steal** gives the bus back after every byte.
- **Request** paces bytes by a peripheral request line (`dreq`) and drops the bus whenever that line is low at the end of a byte.

At the end of the block, `busy` falls and the sticky `done` flag rises, which can serve as an interrupt.

Top module: `dma_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `bus_valid` are all low.
- R2: A `start` pulse while idle captures the whole configuration and raises `busy`. A `start` pulse while `busy` is high has no effect on the running transfer.
- R3: Each byte is one read cycle from the source (`bus_write`=0) followed by one write cycle to the destination (`bus_write`=1) carrying the byte just read. `bus_io` equals the I/O flag of the side being accessed.
- R4: Step code 0 increments, 1 decrements and 2 holds a memory-side address after each byte. An I/O-side address never moves, whatever its step code.
- R5: Addresses are full 20-bit values. A step carries or borrows across bit 16, so a block crosses 64K boundaries, and wraps modulo 2^20.
- R6: Exactly N bytes are moved for a loaded count N. A loaded count of 0 moves 2^CNT_W bytes (65536 at the default width).
- R7: `busy` falls and `done` rises on the edge that completes the last write. `done` stays high until the next accepted `start`.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_write` and `bus_io` hold their values into the next cycle.
- R9: `bus_valid` is high only while both `bus_req` and `bus_grant` are high. Without grant, no bus cycle is offered.
- R10: In burst mode (code 1, and code 3 treated the same), `bus_req` stays high from the first cycle after `start` until the last byte completes.
- R11: In cycle-steal mode (code 2), `bus_req` is low for at least one cycle after every byte except the last.
- R12: In request mode (code 0), a byte starts only while `dreq` is high. If `dreq` is low when a byte's write completes, `bus_req` drops and no further cycle occurs until `dreq` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block with the present configuration |
| cfg_src_addr | input | ADDR_W | Starting source address |
| cfg_dst_addr | input | ADDR_W | Starting destination address |
| cfg_count | input | CNT_W | Byte count, 0 means 2^CNT_W |
| cfg_src_io | input | 1 | Source side is I/O space |
| cfg_dst_io | input | 1 | Destination side is I/O space |
| cfg_src_step | input | 2 | Source step: 0 inc, 1 dec, 2 hold |
| cfg_dst_step | input | 2 | Destination step: 0 inc, 1 dec, 2 hold |
| cfg_mode | input | 2 | 0 request, 1 burst, 2 cycle steal, 3 burst |
| dreq | input | 1 | Peripheral request |
| bus_req | output | 1 | Bus ownership request to the CPU |
| bus_grant | input | 1 | Bus ownership grant from the CPU |
| bus_valid | output | 1 | Bus cycle offered |
| bus_ready | input | 1 | Bus cycle accepted this edge |
| bus_write | output | 1 | 1 write cycle, 0 read cycle |
| bus_io | output | 1 | Cycle targets I/O space |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| busy | output | 1 | Block in progress |
| done | output | 1 | Sticky end-of-block flag |

## Verification
The bench builds the engine with ADDR_W=20 and CNT_W=8. A loaded count of zero then means 256 bytes rather than 65536, so the zero-count block fits in a short run while still exercising the full roll-over of the counter. Keeping the 20-bit address width lets the same short blocks cross the 64K carry at bit 16 and the wrap at the top of the 1MB space. The bench also runs with a throttled `bus_ready` and with `bus_grant` withheld, so that hold-under-back-pressure and grant gating are observed directly.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XFER_REQ   = 2'd0,
    XFER_BURST = 2'd1,
    XFER_STEAL = 2'd2,
    XFER_ALT   = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    STEP_INC  = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_HOLD = 2'd2,
    STEP_RSV  = 2'd3
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DRQ,
    ST_REQ,
    ST_READ,
    ST_WRITE,
    ST_GAP
  } xfer_state_e;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_io,
  input  logic [1:0]        load_step,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              io
);
  step_e step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      io     <= 1'b0;
      step_q <= STEP_HOLD;
    end else if (load) begin
      addr   <= load_addr;
      io     <= load_io;
      step_q <= step_e'(load_step);
    end else if (adv && !io) begin
      case (step_q)
        STEP_INC: addr <= addr + ADDR_W'(1);
        STEP_DEC: addr <= addr - ADDR_W'(1);
        default:  addr <= addr;
      endcase
    end
  end

  // An I/O-side pointer never moves once loaded
  assert_io_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io && !load) |=> $stable(addr));
endmodule

// File: rtl/dma_count.sv
module dma_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - CNT_W'(1);
  end

  // zero loaded rolls to all ones, giving 2^CNT_W bytes before reaching 1
  assign last = (left_q == CNT_W'(1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(left_q));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode_in,
  input  logic       dreq,
  input  logic       grant,
  input  logic       ready,
  input  logic       last,
  output logic       load,
  output logic       rd_fire,
  output logic       wr_fire,
  output logic       bus_req,
  output logic       bus_valid,
  output logic       wr_phase,
  output logic       busy
);
  xfer_state_e state_q, state_d;
  xfer_mode_e  mode_q;
  logic        is_burst;

  assign is_burst  = (mode_q == XFER_BURST) || (mode_q == XFER_ALT);
  assign busy      = (state_q != ST_IDLE);
  assign load      = start && (state_q == ST_IDLE);
  assign bus_req   = (state_q == ST_REQ) || (state_q == ST_READ) || (state_q == ST_WRITE);
  assign wr_phase  = (state_q == ST_WRITE);
  assign bus_valid = ((state_q == ST_READ) || (state_q == ST_WRITE)) && grant;
  assign rd_fire   = bus_valid && ready && (state_q == ST_READ);
  assign wr_fire   = bus_valid && ready && (state_q == ST_WRITE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start) state_d = (xfer_mode_e'(mode_in) == XFER_REQ) ? ST_WAIT_DRQ : ST_REQ;
      ST_WAIT_DRQ: if (dreq) state_d = ST_REQ;
      ST_GAP:      state_d = ST_REQ;
      ST_REQ:      if (grant) state_d = ST_READ;
      ST_READ:     if (rd_fire) state_d = ST_WRITE;
      ST_WRITE: begin
        if (wr_fire) begin
          if (last)                    state_d = ST_IDLE;
          else if (is_burst)           state_d = ST_READ;
          else if (mode_q == XFER_REQ) state_d = dreq ? ST_READ : ST_WAIT_DRQ;
          else                         state_d = ST_GAP;
        end
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= XFER_BURST;
    end else begin
      state_q <= state_d;
      if (load) mode_q <= xfer_mode_e'(mode_in);
    end
  end

  assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_burst && bus_req && !(wr_fire && last)) |=> bus_req);

  assert_steal_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XFER_STEAL && wr_fire && !last) |=> !bus_req);

  assert_drq_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XFER_REQ && wr_fire && !last && !dreq) |=> !bus_req);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_src_io,
  input  logic              cfg_dst_io,
  input  logic [1:0]        cfg_src_step,
  input  logic [1:0]        cfg_dst_step,
  input  logic [1:0]        cfg_mode,
  input  logic              dreq,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic              bus_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done
);
  localparam int SIDES = 2;

  logic              load, rd_fire, wr_fire, wr_phase, last;
  logic [7:0]        hold_q;
  logic [ADDR_W-1:0] side_init [SIDES];
  logic              side_io_init [SIDES];
  logic [1:0]        side_step [SIDES];
  logic [ADDR_W-1:0] side_addr [SIDES];
  logic              side_io [SIDES];

  assign side_init[0]    = cfg_src_addr;
  assign side_init[1]    = cfg_dst_addr;
  assign side_io_init[0] = cfg_src_io;
  assign side_io_init[1] = cfg_dst_io;
  assign side_step[0]    = cfg_src_step;
  assign side_step[1]    = cfg_dst_step;

  dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(cfg_mode), .dreq(dreq),
    .grant(bus_grant), .ready(bus_ready), .last(last), .load(load),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .bus_req(bus_req),
    .bus_valid(bus_valid), .wr_phase(wr_phase), .busy(busy)
  );

  dma_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_count),
    .dec(wr_fire), .last(last)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_addr_step #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(side_init[s]),
      .load_io(side_io_init[s]), .load_step(side_step[s]), .adv(wr_fire),
      .addr(side_addr[s]), .io(side_io[s])
    );
  end

  assign bus_write = wr_phase;
  assign bus_addr  = wr_phase ? side_addr[1] : side_addr[0];
  assign bus_io    = wr_phase ? side_io[1]   : side_io[0];
  assign bus_wdata = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      done   <= 1'b0;
    end else begin
      if (rd_fire) hold_q <= bus_rdata;
      if (load) done <= 1'b0;
      else if (wr_fire && last) done <= 1'b1;
    end
  end

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_io)));

  assert_valid_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_req && bus_grant));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int CW = 8;
  localparam int LOGN = 1024;
  localparam int NVEC = 6;

  // row: src, dst, count, src_io, dst_io, src_step, dst_step, mode, stall
  localparam logic [56:0] VEC [NVEC] = '{
    {20'h0FFFE, 20'h2FFFF, 8'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 1'b0},
    {20'h10001, 20'h00040, 8'd4, 1'b0, 1'b1, 2'd1, 2'd0, 2'd1, 1'b1},
    {20'h00080, 20'hFFFFE, 8'd3, 1'b1, 1'b0, 2'd1, 2'd0, 2'd2, 1'b0},
    {20'h12345, 20'h54321, 8'd6, 1'b0, 1'b0, 2'd2, 2'd1, 2'd2, 1'b1},
    {20'h00011, 20'h00022, 8'd2, 1'b1, 1'b1, 2'd0, 2'd1, 2'd0, 1'b0},
    {20'h30000, 20'h4FF80, 8'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic cfg_src_io = 1'b0, cfg_dst_io = 1'b0;
  logic [1:0] cfg_src_step = '0, cfg_dst_step = '0, cfg_mode = '0;
  logic dreq = 1'b0, bus_grant = 1'b0, bus_ready = 1'b0;
  logic bus_req, bus_valid, bus_write, bus_io, busy, done;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic stall_en = 1'b0, grant_block = 1'b0;
  int cyc = 0, errors = 0, checks = 0;
  int nr = 0, nw = 0, gaps = 0;
  logic [AW-1:0] rd_a [LOGN];
  logic rd_io [LOGN];
  logic [AW-1:0] wr_a [LOGN];
  logic wr_io [LOGN];
  logic [7:0] wr_d [LOGN];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a, logic io);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ (io ? 8'h5A : 8'h00);
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] base, logic io, logic [1:0] st, int k);
    if (io || st >= 2'd2) return base;
    if (st == 2'd0) return base + AW'(k);
    return base - AW'(k);
  endfunction

  assign bus_rdata = mem_byte(bus_addr, bus_io);

  dma_engine #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src_addr(cfg_src_addr),
    .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count), .cfg_src_io(cfg_src_io),
    .cfg_dst_io(cfg_dst_io), .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_mode(cfg_mode), .dreq(dreq), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_ready <= !stall_en || (cyc % 3 != 0);
    bus_grant <= bus_req && !grant_block;
  end

  always @(negedge clk) begin
    if (bus_valid && bus_ready) begin
      if (bus_write) begin
        wr_a[nw % LOGN] = bus_addr; wr_io[nw % LOGN] = bus_io; wr_d[nw % LOGN] = bus_wdata;
        nw++;
      end else begin
        rd_a[nr % LOGN] = bus_addr; rd_io[nr % LOGN] = bus_io;
        nr++;
      end
    end
    if (busy && !bus_req) gaps++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic kick(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] n,
                      input logic sio, input logic dio, input logic [1:0] ss, input logic [1:0] ds,
                      input logic [1:0] m);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_count = n; cfg_src_io = sio; cfg_dst_io = dio;
    cfg_src_step = ss; cfg_dst_step = ds; cfg_mode = m;
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) tick();
  endtask

  // compares logged traffic from log positions r0/w0 against the expected block
  task automatic compare(input int r0, input int w0, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int n, input logic sio, input logic dio, input logic [1:0] ss,
                         input logic [1:0] ds, input string tag);
    int bad_r = 0, bad_w = 0;
    for (int k = 0; k < n && k < LOGN; k++) begin
      logic [AW-1:0] ea, eb;
      ea = exp_addr(s, sio, ss, k);
      eb = exp_addr(d, dio, ds, k);
      if (rd_a[(r0 + k) % LOGN] !== ea || rd_io[(r0 + k) % LOGN] !== sio) bad_r++;
      if (wr_a[(w0 + k) % LOGN] !== eb || wr_io[(w0 + k) % LOGN] !== dio ||
          wr_d[(w0 + k) % LOGN] !== mem_byte(ea, sio)) bad_w++;
    end
    check(bad_r == 0, {tag, " R3 R4 R5 read side"}, bad_r, 0);
    check(bad_w == 0, {tag, " R3 R4 R5 write side"}, bad_w, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, w0, g0, n;
    repeat (3) tick();
    // R1 reset state
    check(!busy && !done && !bus_req && !bus_valid, "R1 reset outputs",
          {busy, done, bus_req, bus_valid}, 0);
    rst_n = 1'b1;
    tick();

    // table walk
    dreq = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      logic [56:0] row;
      row = VEC[v];
      n = (row[16:9] == 8'd0) ? 256 : int'(row[16:9]);
      stall_en = row[0];
      r0 = nr; w0 = nw; g0 = gaps;
      kick(row[56:37], row[36:17], row[16:9], row[8], row[7], row[6:5], row[4:3], row[2:1]);
      check(busy, "R2 busy after start", busy, 1);
      wait_done(3000);
      check(nw - w0 == n && nr - r0 == n, "R6 byte count", nw - w0, n);
      check(done && !busy, "R7 done set, busy clear", {done, busy}, 2);
      compare(r0, w0, row[56:37], row[36:17], n, row[8], row[7], row[6:5], row[4:3], $sformatf("vec%0d", v));
      if (row[2:1] == 2'd1 || row[2:1] == 2'd3)
        check(gaps == g0, "R10 burst keeps bus", gaps - g0, 0);
      if (row[2:1] == 2'd2)
        check(gaps - g0 >= n - 1, "R11 steal releases bus", gaps - g0, n - 1);
    end
    stall_en = 1'b0;

    // R7 done stays until next start, cleared by it
    repeat (5) tick();
    check(done, "R7 done sticky", done, 1);
    kick(20'h00500, 20'h00600, 8'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1);
    check(!done, "R7 done cleared by start", done, 0);
    wait_done(100);

    // R12 request pacing
    dreq = 1'b0; r0 = nr; w0 = nw;
    kick(20'h01000, 20'h02000, 8'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
    repeat (10) tick();
    check(nw == w0 && !bus_req, "R12 no cycle without dreq", nw - w0, 0);
    dreq = 1'b1;
    for (int i = 0; i < 50 && nw == w0; i++) tick();
    dreq = 1'b0;
    repeat (10) tick();
    check(nw - w0 == 1 && !bus_req && busy, "R12 bus dropped after byte", nw - w0, 1);
    dreq = 1'b1;
    wait_done(200);
    check(nw - w0 == 3, "R12 resumes on dreq", nw - w0, 3);
    compare(r0, w0, 20'h01000, 20'h02000, 3, 1'b0, 1'b0, 2'd0, 2'd0, "req");

    // R2 start while busy ignored
    stall_en = 1'b1; r0 = nr; w0 = nw;
    kick(20'h00100, 20'h00200, 8'd4, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1);
    repeat (2) tick();
    kick(20'h0AAAA, 20'h0BBBB, 8'd9, 1'b1, 1'b1, 2'd1, 2'd1, 2'd2);
    wait_done(300);
    check(nw - w0 == 4, "R2 count unchanged by second start", nw - w0, 4);
    compare(r0, w0, 20'h00100, 20'h00200, 4, 1'b0, 1'b0, 2'd0, 2'd0, "R2 busy-start");
    stall_en = 1'b0;

    // R9 no bus cycle without grant
    grant_block = 1'b1; r0 = nr;
    kick(20'h00700, 20'h00800, 8'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1);
    repeat (8) tick();
    check(nr == r0 && !bus_valid && bus_req, "R9 waits for grant", nr - r0, 0);
    grant_block = 1'b0;
    wait_done(100);
    check(done && nr - r0 == 1, "R9 proceeds after grant", nr - r0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule